// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Write Sequencer

This block turns a tuning request into a train of register writes aimed at a single PHY control register. The PHY's tuning space can only be reached one bit at a time. The control register has three parts: a byte-wide bit-address field, a single data bit, and one commit strobe per PHY port. To program a bit, the block sets the address and then the data bit. It then raises the strobe and lowers it again. A request names a start address, a data word, a bit count and the port to program. The block expands that request into four writes per bit, taking the data word least significant bit first and using consecutive addresses.

Two requesters share the sequencer through a fixed-priority arbiter, and only one sequence runs at a time. A shadow copy of the control register is kept, so each write changes only the field that belongs to its step. The `CLEAR_FIRST` parameter selects the newer register layout. In that layout the whole register is written to zero once, before the bit loop starts. The write port is a plain strobe that carries a 32-bit value and a byte enable.

The state machine has seven states. IDLE waits for a grant. CLEAR issues the optional zero write. ADDR writes the address field. DATA writes the data bit with the strobe low. STB_SET raises the strobe. STB_CLR lowers it. DONE signals completion. The transitions are as follows:
- IDLE to CLEAR on a grant when `CLEAR_FIRST` is 1.
- IDLE to ADDR on a grant when `CLEAR_FIRST` is 0 and the length is nonzero.
- IDLE to DONE on a grant when `CLEAR_FIRST` is 0 and the length is zero.
- CLEAR to ADDR for a nonzero length, or CLEAR to DONE for a zero length.
- ADDR to DATA, DATA to STB_SET, and STB_SET to STB_CLR.
- STB_CLR back to ADDR while bits remain, or STB_CLR to DONE after the last bit.
- DONE to IDLE.

Top module: `phy_tune_seq`

## Requirements
- R1: While reset is held and right after it is released, busy, done, wr_en, a_ack and b_ack are all 0.
- R2: If both requesters assert in the same idle cycle, port A is acknowledged and port B is not. A port B request that is still held is acknowledged in the first idle cycle after A's sequence ends.
- R3: No acknowledge is given while busy is 1. A request raised during a sequence has no effect on that sequence's writes.
- R4: With CLEAR_FIRST=1, the first write of every sequence is 0x00000000 with wr_be=4'b1111. With CLEAR_FIRST=0, no such write is issued.
- R5: Each bit takes four writes in this order. First, the address in bits 15:8 with wr_be=4'b1111. Second, the data in bit 7 with the port's strobe bit cleared and wr_be=4'b0001. Third, the strobe bit set. Fourth, the strobe bit cleared. The third and fourth writes use wr_be=4'b0001.
- R6: Bit i of the data word (i=0 is the LSB) is written to address (start + i) mod 256.
- R7: The commit strobe for port n is register bit 2*n.
- R8: A length of 1 to 8 gives that many bits. A length of 0 gives no bit writes. A length above 8 is treated as 8.
- R9: busy rises in the cycle after acceptance and stays high through the DONE cycle. The sequence lasts exactly (number of writes + 1) cycles. done is a one-cycle pulse in the cycle after the last write.
- R10: Every write carries the shadow value, which holds the last value written (0 after reset), with only the current step's field changed. Without CLEAR_FIRST, the data bit left by one sequence therefore appears in the first address write of the next sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Request from port A (higher priority) |
| a_addr | input | 8 | Port A start bit address |
| a_data | input | 8 | Port A data word, LSB first |
| a_len | input | 4 | Port A bit count |
| a_port | input | 2 | Port A PHY port index |
| a_ack | output | 1 | Port A request taken in this cycle |
| b_req | input | 1 | Request from port B (lower priority) |
| b_addr | input | 8 | Port B start bit address |
| b_data | input | 8 | Port B data word, LSB first |
| b_len | input | 4 | Port B bit count |
| b_port | input | 2 | Port B PHY port index |
| b_ack | output | 1 | Port B request taken in this cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| wr_en | output | 1 | Control register write strobe |
| wr_data | output | 32 | Value to write |
| wr_be | output | 4 | Byte enables for the write |

## Verification
The hardest case to reach is a lower-priority request that arrives, or is held, while another sequence is running. The stimulus raises both requests in the same idle cycle and keeps port B asserted through A's whole sequence. It then checks that B gets no acknowledge until the first idle cycle, and that A's writes are unaffected. The shadow carry-over only shows up without the clear step. A second instance with CLEAR_FIRST=0 therefore runs two sequences back to back, and the bench checks that the last data bit of the first sequence appears in the first address write of the second.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ADDR,
        ST_DATA,
        ST_STB_SET,
        ST_STB_CLR,
        ST_DONE
    } step_t;
endpackage

// File: rtl/phy_tune_arb.sv
module phy_tune_arb #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 4,
    parameter int PORT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              a_req,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic [LEN_W-1:0]  a_len,
    input  logic [PORT_W-1:0] a_port,
    input  logic              b_req,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    input  logic [LEN_W-1:0]  b_len,
    input  logic [PORT_W-1:0] b_port,
    output logic              a_ack,
    output logic              b_ack,
    output logic              grant,
    output logic [ADDR_W-1:0] g_addr,
    output logic [DATA_W-1:0] g_data,
    output logic [LEN_W-1:0]  g_len,
    output logic [PORT_W-1:0] g_port
);
    // Port A always wins a tie
    assign a_ack = idle && a_req;
    assign b_ack = idle && b_req && !a_req;
    assign grant = a_ack || b_ack;

    always_comb begin
        if (a_req) begin
            g_addr = a_addr;
            g_data = a_data;
            g_len  = a_len;
            g_port = a_port;
        end else begin
            g_addr = b_addr;
            g_data = b_data;
            g_len  = b_len;
            g_port = b_port;
        end
    end

    // R2
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_ack, b_ack}));
    // R2
    b_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && b_req) |-> !b_ack);
endmodule

// File: rtl/phy_tune_word.sv
module phy_tune_word
    import phy_tune_pkg::*;
#(
    parameter int REG_W    = 32,
    parameter int ADDR_W   = 8,
    parameter int PORT_W   = 2,
    parameter int ADDR_LSB = 8,
    parameter int DATA_BIT = 7
) (
    input  step_t               step,
    input  logic [REG_W-1:0]    shadow,
    input  logic [ADDR_W-1:0]   cur_addr,
    input  logic                cur_bit,
    input  logic [PORT_W-1:0]   cur_port,
    output logic                wr_en,
    output logic [REG_W-1:0]    wr_value,
    output logic [REG_W/8-1:0]  wr_be
);
    localparam int BE_W = REG_W / 8;
    localparam logic [BE_W-1:0] BE_ALL   = '1;
    localparam logic [BE_W-1:0] BE_BYTE0 = BE_W'(1);

    logic [REG_W-1:0] stb_mask;

    always_comb begin
        stb_mask = '0;
        stb_mask[{cur_port, 1'b0}] = 1'b1;
    end

    always_comb begin
        wr_en    = 1'b0;
        wr_value = shadow;
        wr_be    = '0;
        unique case (step)
            ST_CLEAR: begin
                wr_en    = 1'b1;
                wr_value = '0;
                wr_be    = BE_ALL;
            end
            ST_ADDR: begin
                wr_en    = 1'b1;
                wr_value[ADDR_LSB +: ADDR_W] = cur_addr;
                wr_be    = BE_ALL;
            end
            ST_DATA: begin
                wr_en    = 1'b1;
                wr_value = shadow & ~stb_mask;
                wr_value[DATA_BIT] = cur_bit;
                wr_be    = BE_BYTE0;
            end
            ST_STB_SET: begin
                wr_en    = 1'b1;
                wr_value = shadow | stb_mask;
                wr_be    = BE_BYTE0;
            end
            ST_STB_CLR: begin
                wr_en    = 1'b1;
                wr_value = shadow & ~stb_mask;
                wr_be    = BE_BYTE0;
            end
            default: begin
                wr_en    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/phy_tune_fsm.sv
module phy_tune_fsm
    import phy_tune_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 4,
    parameter int PORT_W      = 2,
    parameter int REG_W       = 32,
    parameter bit CLEAR_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [ADDR_W-1:0] g_addr,
    input  logic [DATA_W-1:0] g_data,
    input  logic [LEN_W-1:0]  g_len,
    input  logic [PORT_W-1:0] g_port,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_value,
    output step_t             step,
    output logic [REG_W-1:0]  shadow,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_bit,
    output logic [PORT_W-1:0] cur_port,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(DATA_W);

    step_t             state, nstate;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] bits_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [PORT_W-1:0] port_q;
    logic [REG_W-1:0]  shadow_q;
    logic              empty_q;
    logic [LEN_W-1:0]  g_eff;
    logic              g_empty;
    logic              last_bit;

    assign g_eff    = (g_len > LEN_CAP) ? LEN_CAP : g_len;
    assign g_empty  = (g_len == '0);
    assign last_bit = (idx_q == last_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (grant) begin
                    if (CLEAR_FIRST)  nstate = ST_CLEAR;
                    else if (g_empty) nstate = ST_DONE;
                    else              nstate = ST_ADDR;
                end
            end
            ST_CLEAR:   nstate = empty_q ? ST_DONE : ST_ADDR;
            ST_ADDR:    nstate = ST_DATA;
            ST_DATA:    nstate = ST_STB_SET;
            ST_STB_SET: nstate = ST_STB_CLR;
            ST_STB_CLR: nstate = last_bit ? ST_DONE : ST_ADDR;
            ST_DONE:    nstate = ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            bits_q   <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            port_q   <= '0;
            empty_q  <= 1'b0;
            shadow_q <= '0;
        end else begin
            if (state == ST_IDLE && grant) begin
                base_q  <= g_addr;
                bits_q  <= g_data;
                port_q  <= g_port;
                last_q  <= IDX_W'(g_eff - LEN_W'(1));
                empty_q <= g_empty;
                idx_q   <= '0;
            end else if (state == ST_STB_CLR && !last_bit) begin
                idx_q  <= idx_q + IDX_W'(1);
                bits_q <= bits_q >> 1;
            end
            if (wr_en) shadow_q <= wr_value;
        end
    end

    assign step     = state;
    assign shadow   = shadow_q;
    assign cur_addr = base_q + ADDR_W'(idx_q);
    assign cur_bit  = bits_q[0];
    assign cur_port = port_q;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);

    // R5
    stb_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STB_SET) |-> ($past(state) == ST_DATA));
    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && $past(state) == ST_STB_CLR)
            |-> (cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1))));
    // R7
    strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STB_CLR) |=> (shadow_q[{port_q, 1'b0}] == 1'b0));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    clear_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |-> (CLEAR_FIRST && $past(state) == ST_IDLE));
endmodule

// File: rtl/phy_tune_seq.sv
module phy_tune_seq
    import phy_tune_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 4,
    parameter int REG_W       = 32,
    parameter bit CLEAR_FIRST = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 a_req,
    input  logic [ADDR_W-1:0]    a_addr,
    input  logic [DATA_W-1:0]    a_data,
    input  logic [LEN_W-1:0]     a_len,
    input  logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] a_port,
    output logic                 a_ack,
    input  logic                 b_req,
    input  logic [ADDR_W-1:0]    b_addr,
    input  logic [DATA_W-1:0]    b_data,
    input  logic [LEN_W-1:0]     b_len,
    input  logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] b_port,
    output logic                 b_ack,
    output logic                 busy,
    output logic                 done,
    output logic                 wr_en,
    output logic [REG_W-1:0]     wr_data,
    output logic [REG_W/8-1:0]   wr_be
);
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic              grant;
    logic [ADDR_W-1:0] g_addr;
    logic [DATA_W-1:0] g_data;
    logic [LEN_W-1:0]  g_len;
    logic [PORT_W-1:0] g_port;
    step_t             step;
    logic [REG_W-1:0]  shadow;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_bit;
    logic [PORT_W-1:0] cur_port;

    phy_tune_arb #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .PORT_W(PORT_W)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .idle(!busy),
        .a_req(a_req), .a_addr(a_addr), .a_data(a_data), .a_len(a_len), .a_port(a_port),
        .b_req(b_req), .b_addr(b_addr), .b_data(b_data), .b_len(b_len), .b_port(b_port),
        .a_ack(a_ack), .b_ack(b_ack), .grant(grant),
        .g_addr(g_addr), .g_data(g_data), .g_len(g_len), .g_port(g_port)
    );

    phy_tune_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .PORT_W(PORT_W),
        .REG_W(REG_W), .CLEAR_FIRST(CLEAR_FIRST)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .grant(grant),
        .g_addr(g_addr), .g_data(g_data), .g_len(g_len), .g_port(g_port),
        .wr_en(wr_en), .wr_value(wr_data),
        .step(step), .shadow(shadow), .cur_addr(cur_addr), .cur_bit(cur_bit),
        .cur_port(cur_port), .busy(busy), .done(done)
    );

    phy_tune_word #(
        .REG_W(REG_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W), .ADDR_LSB(8), .DATA_BIT(7)
    ) u_word (
        .step(step), .shadow(shadow), .cur_addr(cur_addr), .cur_bit(cur_bit),
        .cur_port(cur_port), .wr_en(wr_en), .wr_value(wr_data), .wr_be(wr_be)
    );

    // R3
    no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(a_ack || b_ack));
    // R9
    busy_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ack || b_ack) |=> busy);
endmodule

// File: tb/phy_tune_seq_bench.sv
module phy_tune_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        a_req [2];
    logic [7:0]  a_addr [2];
    logic [7:0]  a_data [2];
    logic [3:0]  a_len [2];
    logic [1:0]  a_port [2];
    logic        a_ack [2];
    logic        b_req;
    logic [7:0]  b_addr, b_data;
    logic [3:0]  b_len;
    logic [1:0]  b_port;
    logic        b_ack, b_ack_l;
    logic        busy [2];
    logic        done [2];
    logic        wr_en [2];
    logic [31:0] wr_data [2];
    logic [3:0]  wr_be [2];

    phy_tune_seq u_phy_tune_seq (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req[0]), .a_addr(a_addr[0]), .a_data(a_data[0]), .a_len(a_len[0]),
        .a_port(a_port[0]), .a_ack(a_ack[0]),
        .b_req(b_req), .b_addr(b_addr), .b_data(b_data), .b_len(b_len), .b_port(b_port),
        .b_ack(b_ack), .busy(busy[0]), .done(done[0]),
        .wr_en(wr_en[0]), .wr_data(wr_data[0]), .wr_be(wr_be[0])
    );

    phy_tune_seq #(.CLEAR_FIRST(1'b0)) u_phy_tune_seq_legacy (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req[1]), .a_addr(a_addr[1]), .a_data(a_data[1]), .a_len(a_len[1]),
        .a_port(a_port[1]), .a_ack(a_ack[1]),
        .b_req(1'b0), .b_addr(8'h0), .b_data(8'h0), .b_len(4'h0), .b_port(2'h0),
        .b_ack(b_ack_l), .busy(busy[1]), .done(done[1]),
        .wr_en(wr_en[1]), .wr_data(wr_data[1]), .wr_be(wr_be[1])
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // captured writes per instance
    logic [31:0] cap_v [2][1024];
    logic [3:0]  cap_b [2][1024];
    int          cap_n [2];
    // expected writes
    logic [31:0] exp_v [64];
    logic [3:0]  exp_b [64];
    int          exp_n;
    logic [31:0] msh [2];

    initial begin
        cap_n[0] = 0;
        cap_n[1] = 0;
    end

    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst_n && wr_en[k] && cap_n[k] < 1024) begin
                cap_v[k][cap_n[k]] = wr_data[k];
                cap_b[k][cap_n[k]] = wr_be[k];
                cap_n[k] = cap_n[k] + 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference model of the write train from the requirements
    task automatic model(input int inst, input bit clr, input logic [1:0] p,
                         input logic [7:0] ad, input logic [7:0] d, input logic [3:0] ln);
        int eff;
        logic [31:0] sh;
        sh = msh[inst];
        exp_n = 0;
        eff = (ln > 8) ? 8 : int'(ln);                         // R8
        if (clr) begin                                         // R4
            sh = 32'h0;
            exp_v[exp_n] = sh; exp_b[exp_n] = 4'hF; exp_n++;
        end
        for (int i = 0; i < eff; i++) begin
            sh[15:8] = ad + 8'(i);                             // R6
            exp_v[exp_n] = sh; exp_b[exp_n] = 4'hF; exp_n++;   // R5
            sh[7] = d[i];
            sh[2*p] = 1'b0;                                    // R7
            exp_v[exp_n] = sh; exp_b[exp_n] = 4'h1; exp_n++;
            sh[2*p] = 1'b1;
            exp_v[exp_n] = sh; exp_b[exp_n] = 4'h1; exp_n++;
            sh[2*p] = 1'b0;
            exp_v[exp_n] = sh; exp_b[exp_n] = 4'h1; exp_n++;
        end
        msh[inst] = sh;                                        // R10
    endtask

    task automatic compare(input int inst, input int start, input string tag);
        chk({tag, " R9 write count"}, 32'(cap_n[inst] - start), 32'(exp_n));
        for (int j = 0; j < exp_n && start + j < cap_n[inst]; j++) begin
            chk({tag, " R5 R10 value"}, cap_v[inst][start + j], exp_v[j]);
            chk({tag, " R5 byte enable"}, 32'(cap_b[inst][start + j]), 32'(exp_b[j]));
        end
    endtask

    // wait for done from the first busy cycle, counting busy cycles
    task automatic wait_done(input int inst, output int cyc);
        cyc = 0;
        forever begin
            if (busy[inst]) cyc++;
            if (done[inst] || cyc > 400) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic issue(input int inst, input logic [1:0] p, input logic [7:0] ad,
                         input logic [7:0] d, input logic [3:0] ln, input string tag);
        int start, cyc;
        start = cap_n[inst];
        model(inst, inst == 0, p, ad, d, ln);
        @(negedge clk);
        a_addr[inst] = ad; a_data[inst] = d; a_len[inst] = ln; a_port[inst] = p;
        a_req[inst] = 1'b1;
        #1;
        chk({tag, " R2 ack when idle"}, 32'(a_ack[inst]), 32'd1);
        @(negedge clk);
        a_req[inst] = 1'b0;
        wait_done(inst, cyc);
        chk({tag, " R9 busy length"}, 32'(cyc), 32'(exp_n + 1));
        compare(inst, start, tag);
    endtask

    localparam int NV = 8;
    // {port[1:0], addr[7:0], data[7:0], len[3:0]}
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 8'h20, 8'h14, 4'd5},
        {2'd1, 8'h2a, 8'h02, 4'd2},
        {2'd2, 8'h2a, 8'h03, 4'd2},
        {2'd0, 8'h0c, 8'h01, 4'd1},
        {2'd3, 8'h3c, 8'h00, 4'd2},
        {2'd1, 8'h3c, 8'h02, 4'd2},
        {2'd2, 8'hfe, 8'ha5, 4'd8},
        {2'd3, 8'h10, 8'hff, 4'd12}
    };

    initial begin
        int cyc, start;
        msh[0] = 32'h0;
        msh[1] = 32'h0;
        for (int k = 0; k < 2; k++) begin
            a_req[k] = 1'b0; a_addr[k] = '0; a_data[k] = '0; a_len[k] = '0; a_port[k] = '0;
        end
        b_req = 1'b0; b_addr = '0; b_data = '0; b_len = '0; b_port = '0;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy[0]), 32'd0);
        chk("R1 wr_en in reset", 32'(wr_en[0]), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'({busy[0], busy[1]}), 32'd0);
        chk("R1 done after reset", 32'({done[0], done[1]}), 32'd0);
        chk("R1 wr_en after reset", 32'({wr_en[0], wr_en[1]}), 32'd0);
        chk("R1 acks after reset", 32'({a_ack[0], b_ack}), 32'd0);

        // table walk on the pre-clear instance: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++)
            issue(0, VEC[v][21:20], VEC[v][19:12], VEC[v][11:4], VEC[v][3:0], "table");

        // R8 zero length: only the clear write
        issue(0, 2'd1, 8'h55, 8'hff, 4'd0, "R8 zero len");

        // R2 R3 priority and hold-off
        @(negedge clk);
        a_addr[0] = 8'h40; a_data[0] = 8'h01; a_len[0] = 4'd1; a_port[0] = 2'd0;
        b_addr = 8'h50; b_data = 8'h00; b_len = 4'd1; b_port = 2'd1;
        a_req[0] = 1'b1; b_req = 1'b1;
        #1;
        chk("R2 A wins tie", 32'(a_ack[0]), 32'd1);
        chk("R2 B held off", 32'(b_ack), 32'd0);
        start = cap_n[0];
        model(0, 1'b1, 2'd0, 8'h40, 8'h01, 4'd1);
        @(negedge clk);
        a_req[0] = 1'b0;
        chk("R3 no ack while busy", 32'(b_ack), 32'd0);
        @(negedge clk);
        chk("R3 no ack while busy later", 32'(b_ack), 32'd0);
        cyc = 0;
        while (!done[0] && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        compare(0, start, "R3 A unaffected");
        chk("R2 B acked when idle", 32'(b_ack), 32'd1);
        start = cap_n[0];
        model(0, 1'b1, 2'd1, 8'h50, 8'h00, 4'd1);
        @(negedge clk);
        b_req = 1'b0;
        wait_done(0, cyc);
        compare(0, start, "R2 B sequence");
        chk("R7 port1 strobe bit2", cap_v[0][start + 3], 32'h0000_5004);

        // legacy instance: R4 no clear, R10 carry of data bit
        issue(1, 2'd0, 8'h11, 8'h01, 4'd1, "R4 legacy");
        chk("R4 no clear write", cap_v[1][0], 32'h0000_1100);
        issue(1, 2'd2, 8'h22, 8'h00, 4'd1, "R10 legacy");
        chk("R10 carried data bit", cap_v[1][4], 32'h0000_2280);
        issue(1, 2'd1, 8'h33, 8'h00, 4'd0, "R8 legacy zero len");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule